// File: doc/BRIEF.md
# Prefixed Rotate, Shift and Bit Unit

This block is the purely combinational execution stage for an 8-bit processor's extended bit-manipulation instructions. It covers the prefix-page rotates, shifts and nibble swap, the single-bit test, clear and set operations, and the four short accumulator rotates. It takes one operand byte, the current carry flag, a bit index and a 4-bit operation code. It returns the result byte, a write-back enable, and the four condition flags (zero, subtract, half-carry, carry), each paired with its own update enable.

The surrounding datapath fetches the operand from a register or from memory and decodes the opcode into the operation code below. It writes the result back only when the write-back enable is high, and it loads each flag only when that flag's update enable is high. Flags whose enable is low are driven to zero, so the caller never needs to mask them. A flag that is not updated keeps its previous value in the caller's flag register.

Top module: `bitshift_unit`

## Requirements
- R1: Code 0 (rotate-left circular) gives {a[6:0],a[7]} with C=a[7]. Code 1 (rotate-right circular) gives {a[0],a[7:1]} with C=a[0].
- R2: Code 2 (rotate left through carry) gives {a[6:0],cin} with C=a[7]. Code 3 (rotate right through carry) gives {cin,a[7:1]} with C=a[0].
- R3: Code 4 (shift left) gives {a[6:0],0} with C=a[7]. Code 5 (arithmetic shift right) gives {a[7],a[7:1]} with C=a[0]. Code 7 (logical shift right) gives {0,a[7:1]} with C=a[0].
- R4: Code 6 (nibble swap) gives {a[3:0],a[7:4]} with C=0.
- R5: For codes 0 to 7, write-back is 1 and all four flag enables are 1. Z is 1 exactly when the result byte is zero, and N=H=0.
- R6: Codes 11, 12, 13 and 14 (accumulator rotates) produce the same result and C as codes 0, 1, 2 and 3 respectively. Write-back is 1, all four flag enables are 1, and Z=N=H=0 even when the result is zero.
- R7: Code 8 (bit test) sets Z to the inverse of a[idx], with N=0 and H=1. Z, N and H are updated and C is not. Write-back is 0 and the result equals the operand.
- R8: Codes 9 (clear bit) and 10 (set bit) force bit idx of the operand to 0 or 1 respectively and leave every other bit unchanged. Write-back is 1 and no flag enable is set.
- R9: Code 15 is reserved. It gives write-back 0, no flag enables, and a result equal to the operand.
- R10: Every flag output whose update enable is 0 reads 0. The flag bit order on the ports is {Z,N,H,C}, with Z in bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (see requirements) |
| opnd_i | input | 8 | Operand byte |
| cin_i | input | 1 | Current carry flag |
| idx_i | input | 3 | Bit index for test, clear and set |
| res_o | output | 8 | Result byte |
| wb_en_o | output | 1 | Result must be written back |
| flags_o | output | 4 | Flag values {Z,N,H,C} |
| flag_upd_o | output | 4 | Per-flag update enables {Z,N,H,C} |

## Verification
Random operands are applied to every operation code with both carry-in values and all bit indices. These vectors separate carry-through rotates from circular rotates, and show whether the incoming carry leaks into operations that must ignore it. Directed corners use single-bit operands at bit 0 and bit 7, an all-zero operand and an all-one operand. With these the arithmetic and logical right shifts differ in the top bit, zero results show the computed Z apart from the forced Z of the accumulator rotates, and bit operations at both ends of the byte show off-by-one index faults.

// File: rtl/bsu_pkg.sv
// Shared operation codes and flag layout for the rotate/shift/bit unit.
// Assumes flags are carried as {Z,N,H,C} with Z in the most significant bit.
package bsu_pkg;

    typedef enum logic [3:0] {
        OP_RLC  = 4'd0,
        OP_RRC  = 4'd1,
        OP_RL   = 4'd2,
        OP_RR   = 4'd3,
        OP_SLA  = 4'd4,
        OP_SRA  = 4'd5,
        OP_SWAP = 4'd6,
        OP_SRL  = 4'd7,
        OP_BIT  = 4'd8,
        OP_RES  = 4'd9,
        OP_SET  = 4'd10,
        OP_RLCA = 4'd11,
        OP_RRCA = 4'd12,
        OP_RLA  = 4'd13,
        OP_RRA  = 4'd14,
        OP_RSVD = 4'd15
    } bsu_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } bsu_flags_t;

    // True for the eight prefix-page rotate/shift/swap operations
    function automatic logic is_prefixed_shift(bsu_op_e op);
        return (op inside {OP_RLC, OP_RRC, OP_RL, OP_RR,
                           OP_SLA, OP_SRA, OP_SWAP, OP_SRL});
    endfunction

    // True for the four accumulator rotates
    function automatic logic is_acc_rotate(bsu_op_e op);
        return (op inside {OP_RLCA, OP_RRCA, OP_RLA, OP_RRA});
    endfunction

endpackage

// File: rtl/bsu_shift_rotate.sv
// Rotate, shift and nibble-swap datapath.
// Computes the shifted byte and the carry it produces for every rotate,
// shift and swap code, accumulator rotates included. For any other code the
// outputs are the operand and zero. Assumes WIDTH is even (nibble swap
// exchanges halves).
module bsu_shift_rotate
    import bsu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  bsu_op_e          op,
    input  logic [WIDTH-1:0] opnd,
    input  logic             cin,
    output logic [WIDTH-1:0] res,
    output logic             cout
);
    localparam int HALF = WIDTH / 2;
    localparam int MSB  = WIDTH - 1;

    logic [WIDTH-1:0] swapped;

    // Exchange the two halves of the operand
    assign swapped = {opnd[HALF-1:0], opnd[MSB:HALF]};

    // Select the shifted byte and the carry it produces
    always_comb begin
        res  = opnd;
        cout = 1'b0;
        unique case (op)
            OP_RLC, OP_RLCA: begin
                res  = {opnd[MSB-1:0], opnd[MSB]};
                cout = opnd[MSB];
            end
            OP_RRC, OP_RRCA: begin
                res  = {opnd[0], opnd[MSB:1]};
                cout = opnd[0];
            end
            OP_RL, OP_RLA: begin
                res  = {opnd[MSB-1:0], cin};
                cout = opnd[MSB];
            end
            OP_RR, OP_RRA: begin
                res  = {cin, opnd[MSB:1]};
                cout = opnd[0];
            end
            OP_SLA: begin
                res  = {opnd[MSB-1:0], 1'b0};
                cout = opnd[MSB];
            end
            OP_SRA: begin
                res  = {opnd[MSB], opnd[MSB:1]};
                cout = opnd[0];
            end
            OP_SRL: begin
                res  = {1'b0, opnd[MSB:1]};
                cout = opnd[0];
            end
            OP_SWAP: begin
                res  = swapped;
                cout = 1'b0;
            end
            default: begin
                res  = opnd;
                cout = 1'b0;
            end
        endcase
    end

    // Guard the top-bit fill of the right shifts and the swap carry
    always_comb begin
        if (op == OP_SRA) begin
            p_sra_keeps_msb_r3: assert (res[MSB] == opnd[MSB])
                else $error("arithmetic shift lost the sign bit");
        end
        if (op == OP_SRL) begin
            p_srl_zero_fill_r3: assert (res[MSB] == 1'b0)
                else $error("logical shift filled a one");
        end
        if (op == OP_SWAP) begin
            p_swap_clears_c_r4: assert (cout == 1'b0)
                else $error("swap produced a carry");
        end
    end

endmodule

// File: rtl/bsu_bit_field.sv
// Single-bit test, clear and set datapath.
// Decodes the bit index into a one-hot mask and applies it to the operand.
// Reports the tested bit for every code. For codes other than clear/set the
// result is the operand.
module bsu_bit_field
    import bsu_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int IDX_W = $clog2(WIDTH)
) (
    input  bsu_op_e          op,
    input  logic [WIDTH-1:0] opnd,
    input  logic [IDX_W-1:0] idx,
    output logic [WIDTH-1:0] res,
    output logic             tested
);
    logic [WIDTH-1:0] mask;

    // One-hot decode of the bit index
    for (genvar g = 0; g < WIDTH; g++) begin : g_mask
        assign mask[g] = (idx == IDX_W'(g));
    end

    // The bit under test, read through the mask
    assign tested = |(opnd & mask);

    // Apply clear or set to the selected bit
    always_comb begin
        unique case (op)
            OP_RES:  res = opnd & ~mask;
            OP_SET:  res = opnd | mask;
            default: res = opnd;
        endcase
    end

    // Guard that only the selected bit can change and the mask is one-hot
    always_comb begin
        p_mask_onehot_r8: assert ($onehot(mask))
            else $error("bit index decode is not one-hot");
        if (op == OP_RES || op == OP_SET) begin
            p_only_idx_changes_r8: assert (((res ^ opnd) & ~mask) == '0)
                else $error("bit operation touched another bit");
        end
    end

endmodule

// File: rtl/bsu_flag_ctrl.sv
// Flag and write-back control.
// From the operation class, the datapath result, the shifter carry and the
// tested bit, produces flag values, per-flag update enables and the
// write-back enable. Flag values whose enable is low are forced to zero.
module bsu_flag_ctrl
    import bsu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  bsu_op_e          op,
    input  logic [WIDTH-1:0] res,
    input  logic             cout,
    input  logic             tested,
    output bsu_flags_t       flags,
    output bsu_flags_t       upd,
    output logic             wb_en
);
    logic res_zero;

    // Zero detect on the final result byte
    assign res_zero = ~|res;

    // Per-class flag values, enables and write-back
    always_comb begin
        flags = '0;
        upd   = '0;
        wb_en = 1'b0;
        if (is_prefixed_shift(op)) begin
            flags = '{z: res_zero, n: 1'b0, h: 1'b0, c: cout};
            upd   = '{z: 1'b1, n: 1'b1, h: 1'b1, c: 1'b1};
            wb_en = 1'b1;
        end else if (is_acc_rotate(op)) begin
            flags = '{z: 1'b0, n: 1'b0, h: 1'b0, c: cout};
            upd   = '{z: 1'b1, n: 1'b1, h: 1'b1, c: 1'b1};
            wb_en = 1'b1;
        end else if (op == OP_BIT) begin
            flags = '{z: ~tested, n: 1'b0, h: 1'b1, c: 1'b0};
            upd   = '{z: 1'b1, n: 1'b1, h: 1'b1, c: 1'b0};
            wb_en = 1'b0;
        end else if (op == OP_RES || op == OP_SET) begin
            wb_en = 1'b1;
        end
    end

    // Guard the class rules against the outputs
    always_comb begin
        p_idle_flag_zero_r10: assert ((flags & ~upd) == '0)
            else $error("flag driven without its enable");
        if (op == OP_BIT) begin
            p_bit_no_write_r7: assert (!wb_en && !upd.c && upd.z)
                else $error("bit test wrote back or touched carry");
        end
        if (is_acc_rotate(op)) begin
            p_acc_rot_z_clear_r6: assert (upd.z && !flags.z)
                else $error("accumulator rotate produced Z");
        end
        if (op == OP_RSVD) begin
            p_rsvd_inert_r9: assert (!wb_en && upd == '0)
                else $error("reserved code had an effect");
        end
    end

endmodule

// File: rtl/bitshift_unit.sv
// Top of the rotate/shift/bit execution unit.
// Purely combinational: no clock or reset. Routes the operand through the
// shift/rotate path and the bit-field path, picks the result by operation
// class and hands it to the flag controller. Assumes the caller decodes the
// opcode into op_i and supplies the operand and carry.
module bitshift_unit
    import bsu_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int OP_W  = 4,
    parameter int FLG_W = 4,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [OP_W-1:0]  op_i,
    input  logic [WIDTH-1:0] opnd_i,
    input  logic             cin_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [WIDTH-1:0] res_o,
    output logic             wb_en_o,
    output logic [FLG_W-1:0] flags_o,
    output logic [FLG_W-1:0] flag_upd_o
);
    bsu_op_e          op;
    logic [WIDTH-1:0] sr_res;
    logic             sr_cout;
    logic [WIDTH-1:0] bf_res;
    logic             bf_tested;
    bsu_flags_t       flags;
    bsu_flags_t       upd;

    assign op = bsu_op_e'(op_i);

    bsu_shift_rotate #(.WIDTH(WIDTH)) u_shift (
        .op   (op),
        .opnd (opnd_i),
        .cin  (cin_i),
        .res  (sr_res),
        .cout (sr_cout)
    );

    bsu_bit_field #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_bits (
        .op     (op),
        .opnd   (opnd_i),
        .idx    (idx_i),
        .res    (bf_res),
        .tested (bf_tested)
    );

    // Pick the result from the path that owns the operation
    always_comb begin
        if (is_prefixed_shift(op) || is_acc_rotate(op)) begin
            res_o = sr_res;
        end else if (op == OP_RES || op == OP_SET) begin
            res_o = bf_res;
        end else begin
            res_o = opnd_i;
        end
    end

    bsu_flag_ctrl #(.WIDTH(WIDTH)) u_flags (
        .op     (op),
        .res    (res_o),
        .cout   (sr_cout),
        .tested (bf_tested),
        .flags  (flags),
        .upd    (upd),
        .wb_en  (wb_en_o)
    );

    assign flags_o    = flags;
    assign flag_upd_o = upd;

    // Guard port-level rules of the prefixed group and the inert codes
    always_comb begin
        if (is_prefixed_shift(op)) begin
            p_pfx_z_result_r5: assert (flags_o[3] == (res_o == '0) && flag_upd_o == '1 && wb_en_o)
                else $error("prefixed shift Z or enables wrong");
        end
        if (op == OP_BIT || op == OP_RSVD) begin
            p_no_write_keeps_opnd_r9: assert (res_o == opnd_i)
                else $error("non-writing code altered the result");
        end
        if (op == OP_RES || op == OP_SET) begin
            p_bitop_no_flags_r8: assert (flag_upd_o == '0 && wb_en_o)
                else $error("bit clear/set touched flags");
        end
    end

endmodule

// File: tb/tb_bitshift_unit.sv
module tb_bitshift_unit;

    logic       clk = 1'b0;
    logic [3:0] op_i;
    logic [7:0] opnd_i;
    logic       cin_i;
    logic [2:0] idx_i;
    logic [7:0] res_o;
    logic       wb_en_o;
    logic [3:0] flags_o;
    logic [3:0] flag_upd_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    bitshift_unit dut (
        .op_i       (op_i),
        .opnd_i     (opnd_i),
        .cin_i      (cin_i),
        .idx_i      (idx_i),
        .res_o      (res_o),
        .wb_en_o    (wb_en_o),
        .flags_o    (flags_o),
        .flag_upd_o (flag_upd_o)
    );

    // Requirement tag for an operation code
    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1:                 return "R1/R5";
            4'd2, 4'd3:                 return "R2/R5";
            4'd4, 4'd5, 4'd7:           return "R3/R5";
            4'd6:                       return "R4/R5";
            4'd8:                       return "R7/R10";
            4'd9, 4'd10:                return "R8/R10";
            4'd11, 4'd12, 4'd13, 4'd14: return "R6";
            default:                    return "R9/R10";
        endcase
    endfunction

    // Expected {wb, upd[3:0], flags[3:0], res[7:0]} from the requirements
    function automatic logic [16:0] model(input logic [3:0] op, input logic [7:0] a,
                                          input logic cin, input logic [2:0] idx);
        logic [7:0] r;
        logic       c, wb;
        logic [3:0] u, f;
        r = a; c = 1'b0; wb = 1'b0; u = 4'h0; f = 4'h0;
        case (op)
            4'd0, 4'd11: begin r = {a[6:0], a[7]}; c = a[7]; end
            4'd1, 4'd12: begin r = {a[0], a[7:1]}; c = a[0]; end
            4'd2, 4'd13: begin r = {a[6:0], cin};  c = a[7]; end
            4'd3, 4'd14: begin r = {cin, a[7:1]};  c = a[0]; end
            4'd4: begin r = {a[6:0], 1'b0}; c = a[7]; end
            4'd5: begin r = {a[7], a[7:1]}; c = a[0]; end
            4'd6: begin r = {a[3:0], a[7:4]}; c = 1'b0; end
            4'd7: begin r = {1'b0, a[7:1]}; c = a[0]; end
            default: ;
        endcase
        if (op <= 4'd7) begin
            wb = 1'b1; u = 4'hF; f = {(r == 8'h00), 1'b0, 1'b0, c};         // R5
        end else if (op >= 4'd11 && op <= 4'd14) begin
            wb = 1'b1; u = 4'hF; f = {3'b000, c};                           // R6
        end else if (op == 4'd8) begin
            u = 4'b1110; f = {~a[idx], 1'b0, 1'b1, 1'b0};                   // R7
        end else if (op == 4'd9) begin
            r = a; r[idx] = 1'b0; wb = 1'b1;                                // R8
        end else if (op == 4'd10) begin
            r = a; r[idx] = 1'b1; wb = 1'b1;                                // R8
        end
        return {wb, u, f, r};
    endfunction

    task automatic run_vec(input logic [3:0] op, input logic [7:0] a,
                           input logic cin, input logic [2:0] idx);
        logic [16:0] exp_v, act_v;
        @(negedge clk);
        op_i = op; opnd_i = a; cin_i = cin; idx_i = idx;
        @(posedge clk);
        #1;
        exp_v = model(op, a, cin, idx);
        act_v = {wb_en_o, flag_upd_o, flags_o, res_o};
        n_tests++;
        if (act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%02h cin=%0b idx=%0d actual=%05h expected=%05h",
                     req_of(op), op, a, cin, idx, act_v, exp_v);
        end
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h0BAD5EED);
        op_i = 4'd15; opnd_i = 8'h00; cin_i = 1'b0; idx_i = 3'd0;
        // Initial state: reserved code, zero operand (R9, R10)
        run_vec(4'd15, 8'h00, 1'b0, 3'd0);
        // Directed corners
        run_vec(4'd0,  8'h00, 1'b1, 3'd0);  // R1 zero result, Z=1
        run_vec(4'd1,  8'h01, 1'b0, 3'd0);  // R1 bit 0 wraps to bit 7
        run_vec(4'd2,  8'h80, 1'b1, 3'd0);  // R2 carry enters bit 0
        run_vec(4'd3,  8'h01, 1'b0, 3'd0);  // R2 result zero, C=1
        run_vec(4'd4,  8'h80, 1'b1, 3'd0);  // R3 shift left to zero
        run_vec(4'd5,  8'h81, 1'b0, 3'd0);  // R3 sign kept
        run_vec(4'd7,  8'h81, 1'b1, 3'd0);  // R3 zero fill
        run_vec(4'd7,  8'h01, 1'b1, 3'd0);  // R3 zero result
        run_vec(4'd6,  8'hF0, 1'b1, 3'd0);  // R4 swap, C cleared
        run_vec(4'd6,  8'h00, 1'b1, 3'd0);  // R4/R5 swap zero
        run_vec(4'd13, 8'h00, 1'b0, 3'd0);  // R6 zero result, Z forced 0
        run_vec(4'd14, 8'h01, 1'b1, 3'd0);  // R6 carry into bit 7
        run_vec(4'd11, 8'h80, 1'b0, 3'd0);  // R6 circular
        run_vec(4'd8,  8'h7F, 1'b1, 3'd7);  // R7 tested bit 0 -> Z=1
        run_vec(4'd8,  8'h01, 1'b1, 3'd0);  // R7 tested bit 1 -> Z=0
        run_vec(4'd9,  8'hFF, 1'b1, 3'd0);  // R8 clear bit 0
        run_vec(4'd9,  8'hFF, 1'b0, 3'd7);  // R8 clear bit 7
        run_vec(4'd10, 8'h00, 1'b1, 3'd7);  // R8 set bit 7
        run_vec(4'd10, 8'h00, 1'b0, 3'd0);  // R8 set bit 0
        run_vec(4'd15, 8'hA5, 1'b1, 3'd5);  // R9 reserved ignored
        // Exhaustive sweep of codes and indices on edge operands
        for (int op = 0; op < 16; op++) begin
            for (int ix = 0; ix < 8; ix++) begin
                run_vec(4'(op), 8'hFF, 1'b0, 3'(ix));
                run_vec(4'(op), 8'h00, 1'b1, 3'(ix));
            end
        end
        // Constrained random: biased toward single-bit and edge operands
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] a;
            case ($urandom % 4)
                0:       a = 8'(1 << ($urandom % 8));
                1:       a = ~8'(1 << ($urandom % 8));
                default: a = 8'($urandom);
            endcase
            run_vec(4'($urandom % 16), a, 1'($urandom), 3'($urandom));
        end
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule